// File: doc/BRIEF.md
# PWM Output Fault-Override Stage

This block is the last stage in front of the pins of an eight-channel timer/PWM. The compare logic gives it one raw waveform bit per channel. In normal operation it can invert each of those bits on its own before driving it to the pin, with the output-enable held high. Two fault event inputs each pass through their own programmable glitch filter. A fault that survives its filter sets a sticky fault flag, and the block then enters a non-recoverable fault state.

In the fault state, each channel does one of two things. It either keeps driving and shows a programmed override level, with no inversion applied, or it releases the pin by dropping its output-enable. The flag stays set until reset or a clear strobe. All settings live in one 32-bit control register. The register takes writes only while the timer is stopped, and it can always be read back.

Top module: `pwm_fault_driver`

## Requirements
- R1: After reset the control register reads 0 and `fault_active` is 0. Every `pwm_oe` bit is 1 and `pwm_out` equals `wave_in`.
- R2: While `run_en` is 0, a cycle with `wr_en` high stores `wr_data`. `rd_data` returns the stored value from the next cycle on.
- R3: While `run_en` is 1, a cycle with `wr_en` high leaves the register unchanged.
- R4: Outside the fault state, every `pwm_oe` bit is 1. `pwm_out[c]` is `wave_in[c]` XOR register bit 16+c, where 1 selects inversion.
- R5: In the fault state, a channel whose register bit c (override enable, bits 7:0) is 1 has `pwm_oe[c]`=1. Its `pwm_out[c]` equals register bit 8+c (override level, bits 15:8), and inversion is not applied.
- R6: In the fault state, a channel whose override enable bit is 0 has `pwm_oe[c]`=0 and `pwm_out[c]`=0.
- R7: With a filter value of 0, a fault input that is high at a single rising clock edge sets `fault_active` from that edge on.
- R8: With a filter value N>0, a fault input must be high at N+1 consecutive rising edges before it sets `fault_active`. A single low sample restarts the count.
- R9: `fault_active` stays set after the fault inputs fall. It clears only on reset or on an edge with `fault_clr` high. When a recognised fault and `fault_clr` arrive at the same edge, the flag stays set.
- R10: Fault input 0 uses the filter value in register bits 27:24. Fault input 1 uses bits 31:28. Each input is filtered independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Timer running; blocks register writes |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write value |
| rd_data | output | 32 | Control register contents |
| wave_in | input | 8 | Raw waveform bits from compare logic |
| fault_in | input | 2 | Fault event inputs |
| fault_clr | input | 1 | Clears the sticky fault flag |
| pwm_out | output | 8 | Waveform output values |
| pwm_oe | output | 8 | Per-channel output-enable (0 = high impedance) |
| fault_active | output | 1 | Non-recoverable fault state flag |

## Verification
The properties assume the fault inputs and `fault_clr` are synchronous to `clk` and stable around each rising edge. They also assume the control register changes only through the write port. The bench drives every input one nanosecond after a rising edge and samples there too. It reprograms the register only with `run_en` low, or deliberately with it high to exercise the write block. Asynchronous fault events are modelled only as single-cycle synchronous pulses with a filter value of 0.

// File: rtl/pwm_drv_pkg.sv
package pwm_drv_pkg;

  localparam int unsigned DEF_CH  = 8;
  localparam int unsigned DEF_FLT = 2;
  localparam int unsigned DEF_FW  = 4;

  // Per-channel output value: override level in fault, else optionally inverted wave
  function automatic logic chan_value(input logic wave, input logic inv,
                                      input logic fault, input logic ovr_en,
                                      input logic ovr_lvl);
    if (fault) return ovr_en & ovr_lvl;
    return wave ^ inv;
  endfunction

  // Per-channel output enable
  function automatic logic chan_enable(input logic fault, input logic ovr_en);
    return fault ? ovr_en : 1'b1;
  endfunction

endpackage

// File: rtl/pwm_drv_ctrl_reg.sv
module pwm_drv_ctrl_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  logic wr_accept;
  assign wr_accept = wr_en & ~run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (wr_accept) q <= wr_data;
  end

endmodule

// File: rtl/pwm_flt_filter.sv
module pwm_flt_filter #(
  parameter int unsigned FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flt_in,
  input  logic [FW-1:0] thresh,
  output logic          hit
);

  logic [FW-1:0] run_cnt;

  // run_cnt = number of consecutive high samples already seen, saturating at thresh
  assign hit = flt_in && (run_cnt >= thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt <= '0;
    else if (!flt_in)          run_cnt <= '0;
    else if (run_cnt < thresh) run_cnt <= run_cnt + 1'b1;
  end

endmodule

// File: rtl/pwm_fault_latch.sv
module pwm_fault_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         clr,
  output logic         active
);

  logic any_hit;
  assign any_hit = |hit;

  // A new fault outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active <= 1'b0;
    else if (any_hit) active <= 1'b1;
    else if (clr)     active <= 1'b0;
  end

endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out
  import pwm_drv_pkg::*;
(
  input  logic wave,
  input  logic inv,
  input  logic fault,
  input  logic ovr_en,
  input  logic ovr_lvl,
  output logic out,
  output logic oe
);

  assign out = chan_value(wave, inv, fault, ovr_en, ovr_lvl);
  assign oe  = chan_enable(fault, ovr_en);

endmodule

// File: rtl/pwm_fault_driver.sv
module pwm_fault_driver
  import pwm_drv_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_CH,
  parameter int unsigned NUM_FLT = DEF_FLT,
  parameter int unsigned FLT_W   = DEF_FW,
  parameter int unsigned CTRL_W  = 3 * NUM_CH + NUM_FLT * FLT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] wave_in,
  input  logic [NUM_FLT-1:0] fault_in,
  input  logic              fault_clr,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe,
  output logic              fault_active
);

  localparam int unsigned EN_LO  = 0;
  localparam int unsigned LVL_LO = NUM_CH;
  localparam int unsigned INV_LO = 2 * NUM_CH;
  localparam int unsigned FLT_LO = 3 * NUM_CH;

  logic [CTRL_W-1:0]  ctrl_q;
  logic [NUM_CH-1:0]  ovr_en;
  logic [NUM_CH-1:0]  ovr_lvl;
  logic [NUM_CH-1:0]  inv_sel;
  logic [NUM_FLT-1:0] fault_hit;

  pwm_drv_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .q       (ctrl_q)
  );

  assign rd_data = ctrl_q;
  assign ovr_en  = ctrl_q[EN_LO  +: NUM_CH];
  assign ovr_lvl = ctrl_q[LVL_LO +: NUM_CH];
  assign inv_sel = ctrl_q[INV_LO +: NUM_CH];

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    pwm_flt_filter #(.FW(FLT_W)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .flt_in (fault_in[g]),
      .thresh (ctrl_q[FLT_LO + g * FLT_W +: FLT_W]),
      .hit    (fault_hit[g])
    );
  end

  pwm_fault_latch #(.N(NUM_FLT)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (fault_hit),
    .clr    (fault_clr),
    .active (fault_active)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan_out u_ch (
      .wave    (wave_in[c]),
      .inv     (inv_sel[c]),
      .fault   (fault_active),
      .ovr_en  (ovr_en[c]),
      .ovr_lvl (ovr_lvl[c]),
      .out     (pwm_out[c]),
      .oe      (pwm_oe[c])
    );
  end

endmodule

// File: rtl/pwm_fault_driver_sva.sv
module pwm_fault_driver_sva #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_FLT = 2,
  parameter int unsigned CTRL_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic [CTRL_W-1:0] rd_data,
  input logic [NUM_CH-1:0] ovr_en,
  input logic [NUM_CH-1:0] ovr_lvl,
  input logic [NUM_FLT-1:0] fault_hit,
  input logic              fault_clr,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] pwm_oe,
  input logic              fault_active
);

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !run_en) |=> (rd_data == $past(wr_data)));                     // R2

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_en) |=> $stable(rd_data));                                 // R3

  AST_NORMAL_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_active |-> (&pwm_oe));                                            // R4

  AST_OVERRIDE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    fault_active |-> ((pwm_out & ovr_en) == (ovr_lvl & ovr_en)));            // R5

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_active |-> ((pwm_oe == ovr_en) && ((pwm_out & ~ovr_en) == '0)));   // R6

  AST_SET_BY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_active) |-> $past(|fault_hit));                              // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active && !fault_clr) |=> fault_active);                          // R9

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !(|fault_hit)) |=> !fault_active);                         // R9

  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_hit) |=> fault_active);                                          // R9

endmodule

bind pwm_fault_driver pwm_fault_driver_sva #(
  .NUM_CH  (NUM_CH),
  .NUM_FLT (NUM_FLT),
  .CTRL_W  (CTRL_W)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_en       (run_en),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .ovr_en       (ovr_en),
  .ovr_lvl      (ovr_lvl),
  .fault_hit    (fault_hit),
  .fault_clr    (fault_clr),
  .pwm_out      (pwm_out),
  .pwm_oe       (pwm_oe),
  .fault_active (fault_active)
);

// File: tb/pwm_fault_driver_test.sv
module pwm_fault_driver_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  wave_in = '0;
  logic [1:0]  fault_in = '0;
  logic        fault_clr = 1'b0;
  logic [7:0]  pwm_out;
  logic [7:0]  pwm_oe;
  logic        fault_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pwm_fault_driver uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .wave_in(wave_in),
    .fault_in(fault_in), .fault_clr(fault_clr), .pwm_out(pwm_out),
    .pwm_oe(pwm_oe), .fault_active(fault_active)
  );

  // {fault, ctrl, wave, exp_out, exp_oe}
  localparam int NV = 7;
  localparam logic [56:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 8'hA5, 8'hA5, 8'hFF},  // R4 no inversion
    {1'b0, 32'h00FF_0000, 8'hA5, 8'h5A, 8'hFF},  // R4 all inverted
    {1'b0, 32'h000F_0000, 8'h3C, 8'h33, 8'hFF},  // R4 low nibble inverted
    {1'b1, 32'h00FF_F0FF, 8'h55, 8'hF0, 8'hFF},  // R5 level ignores inversion
    {1'b1, 32'h0000_AA0F, 8'hFF, 8'h0A, 8'h0F},  // R5/R6 mixed
    {1'b1, 32'h0000_FF00, 8'hFF, 8'h00, 8'h00},  // R6 all released
    {1'b1, 32'h0033_3C3C, 8'hFF, 8'h3C, 8'h3C}   // R5/R6 mixed with inversion
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    run_en = 1'b0; wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic clr();
    fault_clr = 1'b1;
    tick();
    fault_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    wave_in = 8'hC3;
    #1;
    // R1 reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 fault_active", {31'b0, fault_active}, 32'h0);
    chk("R1 pwm_oe", {24'b0, pwm_oe}, 32'hFF);
    chk("R1 pwm_out", {24'b0, pwm_out}, 32'hC3);
    tick();

    // Vector table: R4, R5, R6 with filters at 0 (R7)
    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      v = VEC[i];
      clr();
      wr(v[55:24]);
      chk("R2 readback", rd_data, v[55:24]);
      wave_in = v[23:16];
      if (v[56]) begin
        fault_in = 2'b01;
        tick();
        fault_in = 2'b00;
      end else begin
        #1;
      end
      chk("R7 fault state", {31'b0, fault_active}, {31'b0, v[56]});
      chk("R4/R5/R6 pwm_out", {24'b0, pwm_out}, {24'b0, v[15:8]});
      chk("R4/R5/R6 pwm_oe", {24'b0, pwm_oe}, {24'b0, v[7:0]});
      tick();
    end

    // R3 write ignored while running
    clr();
    wr(32'h0000_00AA);
    run_en = 1'b1; wr_en = 1'b1; wr_data = 32'h1234_5678;
    tick();
    wr_en = 1'b0; run_en = 1'b0;
    chk("R3 write blocked", rd_data, 32'h0000_00AA);

    // R8 filter value 3 on input 0 (R10 bits 27:24)
    wr(32'h0300_0000);
    clr();
    fault_in = 2'b01;
    repeat (3) tick();
    chk("R8 three edges not enough", {31'b0, fault_active}, 32'h0);
    tick();
    chk("R8 fourth edge recognised", {31'b0, fault_active}, 32'h1);
    fault_in = 2'b00;
    tick();
    chk("R9 sticky after input low", {31'b0, fault_active}, 32'h1);
    clr();
    chk("R9 clear strobe", {31'b0, fault_active}, 32'h0);

    // R8 low sample restarts count
    fault_in = 2'b01;
    repeat (3) tick();
    fault_in = 2'b00;
    tick();
    fault_in = 2'b01;
    repeat (3) tick();
    chk("R8 glitch restarts count", {31'b0, fault_active}, 32'h0);
    tick();
    chk("R8 recognised after restart", {31'b0, fault_active}, 32'h1);
    fault_in = 2'b00;
    clr();

    // R10 input 1 uses bits 31:28 (value 2), input 0 has value 0
    wr(32'h2000_0000);
    fault_in = 2'b10;
    repeat (2) tick();
    chk("R10 input1 two edges", {31'b0, fault_active}, 32'h0);
    tick();
    chk("R10 input1 third edge", {31'b0, fault_active}, 32'h1);
    fault_in = 2'b00;
    clr();

    // R9 fault beats clear in the same cycle
    wr(32'h0000_0000);
    fault_in = 2'b01; fault_clr = 1'b1;
    tick();
    fault_in = 2'b00; fault_clr = 1'b0;
    chk("R9 set wins over clear", {31'b0, fault_active}, 32'h1);
    clr();
    chk("R9 cleared afterwards", {31'b0, fault_active}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule